// File: doc/BRIEF.md
# External Interrupt Request Detector

This block turns slow external request pins into interrupt request flags for an interrupt controller. Each pin is first brought into the clock domain by a two-flop synchronizer. A one-cycle sample strobe, issued once per machine cycle, then samples it. Two general channels each have a mode input. In level mode the channel's flag shows whether the latest sample was low. In edge mode the flag latches when one sample is high and the next sample is low. A third channel, the timer reload trigger, is always edge-triggered and sets its flag only while its enable input is high.

Each channel runs a small sampling state machine with three states. `SMP_UNKNOWN` is the state after reset, when no sample has been taken. `SMP_HIGH` means the latest sample was high, and `SMP_LOW` means it was low. The state moves only on a strobe. The transitions are: unknown→high and unknown→low (the first sample), high→low (the falling transition, which raises the edge event), and low→high (the channel is armed again). A high sample in `SMP_HIGH` or a low sample in `SMP_LOW` keeps the state. The edge-mode flags are held in a latch register. That register takes, in priority order, a per-bit software write, a set from the edge event, and a clear from the hardware acknowledge.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset every flag reads 0, and every channel is in the unknown state. A first sample that is low therefore does not set an edge-mode flag.
- R2: With `edge_mode_i[i]`=0, `flag_o[i]` is 1 exactly when the most recent strobed sample of pin i was low. It returns to 0 after a strobed sample that is high.
- R3: With `edge_mode_i[i]`=1, `flag_o[i]` becomes 1 after a strobe that samples low, provided the previous strobed sample was high.
- R4: Pin activity between strobes has no effect. A low pulse that starts after one strobe and ends before the next strobe is never seen.
- R5: In edge mode a pin that stays low over many strobes sets the flag only once. The channel must be sampled high again before a new edge is detected.
- R6: In edge mode, a one-cycle `hw_ack_i[i]` clears `flag_o[i]` on the next clock edge.
- R7: In level mode `hw_ack_i[i]` has no effect. The flag stays 1 while the sampled pin stays low.
- R8: The trigger channel (bit 2) sets its flag on a high-then-low sample pair only if `trig_en_i` is 1 at the strobe that samples low.
- R9: The trigger flag ignores `hw_ack_i[2]`. It is cleared only through the software write port.
- R10: When `sw_wr_i[i]` is 1, the edge latch of channel i loads `sw_wdata_i[i]`. This takes priority over a set in the same clock. A write to a channel in level mode does not change `flag_o[i]`.
- R11: A pin change driven just before rising edge A is not seen by a strobe at the next rising edge B. It is seen by a strobe at the edge after that, C, because of the two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 3 | Raw request pins; bit 2 is the timer reload trigger |
| smp_stb_i | input | 1 | One-cycle machine-cycle sample strobe |
| edge_mode_i | input | 2 | Per general channel: 1 = falling edge, 0 = low level |
| trig_en_i | input | 1 | Enables flag setting on the trigger channel |
| hw_ack_i | input | 3 | Hardware acknowledge clear per channel |
| sw_wr_i | input | 3 | Per-bit software write enable |
| sw_wdata_i | input | 3 | Software write data |
| flag_o | output | 3 | Interrupt request flags |

## Verification
Both general channels are swept in both modes through every three-sample pattern. After each strobe the expected flag is computed from the sample history: for level mode, whether the last sample was low; for edge mode, whether any high-to-low sample pair has occurred. This separates level tracking from edge latching, and it shows that an initial low or a sustained low is not taken as an edge. Further runs cover the following:
- a glitch between strobes;
- the strobe placed one and two edges after a pin change, which isolates the synchronizer latency;
- the acknowledge in each mode;
- the trigger channel with its enable off and on;
- a software write that collides with a set in the same clock.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic [1:0] {
        SMP_UNKNOWN = 2'd0,
        SMP_HIGH    = 2'd1,
        SMP_LOW     = 2'd2
    } smp_state_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '1;
            stage2_q <= '1;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;

    // R11: the output repeats the first stage one clock later
    p_sync_delay_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> q_o == $past(stage1_q));
endmodule

// File: rtl/irq_sampler.sv
module irq_sampler
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  logic pin_i,
    output logic fall_o,
    output logic low_o
);
    smp_state_e state_q;
    smp_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SMP_UNKNOWN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (stb_i) begin
            unique case (state_q)
                SMP_UNKNOWN: state_d = pin_i ? SMP_HIGH : SMP_LOW;
                SMP_HIGH:    state_d = pin_i ? SMP_HIGH : SMP_LOW;
                SMP_LOW:     state_d = pin_i ? SMP_HIGH : SMP_LOW;
                default:     state_d = SMP_UNKNOWN;
            endcase
        end
    end

    always_comb begin
        fall_o = 1'b0;
        low_o  = 1'b0;
        unique case (state_q)
            SMP_UNKNOWN: ;
            SMP_HIGH:    fall_o = stb_i && !pin_i;
            SMP_LOW:     low_o  = 1'b1;
            default:     ;
        endcase
    end

    p_hold_between_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(state_q));
    p_fall_lands_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> state_q == SMP_LOW);
    p_low_tracks_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i |=> low_o == !$past(pin_i));
endmodule

// File: rtl/irq_flag.sv
module irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic wr_i,
    input  logic wdata_i,
    output logic q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (wr_i)  q_o <= wdata_i;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    p_write_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> q_o == $past(wdata_i));
    p_set_latches_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_i && !wr_i |=> q_o);
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !set_i && !wr_i |=> !q_o);
    p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !set_i && !clr_i && !wr_i |=> $stable(q_o));
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
    parameter int N_EXT = 2,
    localparam int N_PIN = N_EXT + 1,
    localparam int TRIG = N_EXT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PIN-1:0] pin_i,
    input  logic             smp_stb_i,
    input  logic [N_EXT-1:0] edge_mode_i,
    input  logic             trig_en_i,
    input  logic [N_PIN-1:0] hw_ack_i,
    input  logic [N_PIN-1:0] sw_wr_i,
    input  logic [N_PIN-1:0] sw_wdata_i,
    output logic [N_PIN-1:0] flag_o
);
    logic [N_PIN-1:0] pin_sync;
    logic [N_PIN-1:0] fall_evt;
    logic [N_PIN-1:0] low_now;
    logic [N_PIN-1:0] latch_q;

    irq_sync #(.W(N_PIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_sync)
    );

    for (genvar i = 0; i < N_PIN; i++) begin : g_ch
        irq_sampler u_smp (
            .clk    (clk),
            .rst_n  (rst_n),
            .stb_i  (smp_stb_i),
            .pin_i  (pin_sync[i]),
            .fall_o (fall_evt[i]),
            .low_o  (low_now[i])
        );

        if (i < N_EXT) begin : g_gen
            irq_flag u_flag (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_i   (fall_evt[i] && edge_mode_i[i]),
                .clr_i   (hw_ack_i[i] && edge_mode_i[i]),
                .wr_i    (sw_wr_i[i]),
                .wdata_i (sw_wdata_i[i]),
                .q_o     (latch_q[i])
            );
            assign flag_o[i] = edge_mode_i[i] ? latch_q[i] : low_now[i];

            p_level_ignores_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !edge_mode_i[i] && !smp_stb_i |=> edge_mode_i[i] || flag_o[i] == $past(flag_o[i]));
        end else begin : g_trig
            irq_flag u_flag (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_i   (fall_evt[i] && trig_en_i),
                .clr_i   (1'b0),
                .wr_i    (sw_wr_i[i]),
                .wdata_i (sw_wdata_i[i]),
                .q_o     (latch_q[i])
            );
            assign flag_o[i] = latch_q[i];
        end
    end

    p_trig_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o[TRIG]) && !$past(sw_wr_i[TRIG]) |-> $past(trig_en_i));
    p_trig_ignores_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o[TRIG] && !sw_wr_i[TRIG] |=> flag_o[TRIG]);
endmodule

// File: tb/tb_ext_irq_detect.sv
`timescale 1ns/1ps
module tb_ext_irq_detect;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] pin_i;
    logic       smp_stb_i;
    logic [1:0] edge_mode_i;
    logic       trig_en_i;
    logic [2:0] hw_ack_i;
    logic [2:0] sw_wr_i;
    logic [2:0] sw_wdata_i;
    logic [2:0] flag_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ext_irq_detect dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .smp_stb_i(smp_stb_i),
        .edge_mode_i(edge_mode_i), .trig_en_i(trig_en_i), .hw_ack_i(hw_ack_i),
        .sw_wr_i(sw_wr_i), .sw_wdata_i(sw_wdata_i), .flag_o(flag_o)
    );

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] mode);
        @(negedge clk);
        rst_n = 1'b0; pin_i = 3'b111; smp_stb_i = 1'b0; edge_mode_i = mode;
        trig_en_i = 1'b0; hw_ack_i = '0; sw_wr_i = '0; sw_wdata_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic settle(input logic [2:0] v);
        @(negedge clk);
        pin_i = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic strobe();
        smp_stb_i = 1'b1;
        @(negedge clk);
        smp_stb_i = 1'b0;
    endtask

    task automatic pulse_ack(input logic [2:0] m);
        hw_ack_i = m;
        @(negedge clk);
        hw_ack_i = '0;
    endtask

    task automatic sw_write(input logic [2:0] m, input logic [2:0] d);
        sw_wr_i = m; sw_wdata_i = d;
        @(negedge clk);
        sw_wr_i = '0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset(2'b11);
        for (int b = 0; b < 3; b++) check("R1 reset flag", flag_o[b], 1'b0);

        // R2 R3 R5 R1: sweep of all three-sample patterns, both channels, both modes
        for (int mode = 0; mode < 2; mode++) begin
            for (int ch = 0; ch < 2; ch++) begin
                for (int p = 0; p < 8; p++) begin
                    logic prev_valid;
                    logic prev;
                    logic lat;
                    do_reset(mode[0] ? 2'b11 : 2'b00);
                    prev_valid = 1'b0; prev = 1'b1; lat = 1'b0;
                    for (int k = 0; k < 3; k++) begin
                        logic s;
                        logic [2:0] v;
                        s = p[k];
                        v = 3'b111;
                        v[ch] = s;
                        settle(v);
                        strobe();
                        if (prev_valid && prev && !s) lat = 1'b1;
                        prev = s; prev_valid = 1'b1;
                        if (mode == 0) check("R2 level tracks sample", flag_o[ch], !s);
                        else           check("R3/R5/R1 edge latch", flag_o[ch], lat);
                    end
                end
            end
        end

        // R4: low glitch between strobes is missed
        do_reset(2'b01);
        settle(3'b111); strobe();
        settle(3'b110);
        check("R4 no strobe no set", flag_o[0], 1'b0);
        settle(3'b111); strobe();
        check("R4 glitch missed", flag_o[0], 1'b0);

        // R6: ack clears edge-mode flag
        settle(3'b110); strobe();
        check("R6 flag set before ack", flag_o[0], 1'b1);
        pulse_ack(3'b001);
        check("R6 ack clears edge flag", flag_o[0], 1'b0);

        // R7: ack ignored in level mode
        do_reset(2'b00);
        settle(3'b101); strobe();
        pulse_ack(3'b010);
        check("R7 level ack ignored", flag_o[1], 1'b1);

        // R8: trigger needs enable
        for (int en = 0; en < 2; en++) begin
            do_reset(2'b00);
            trig_en_i = en[0];
            settle(3'b111); strobe();
            settle(3'b011); strobe();
            check("R8 trigger enable gating", flag_o[2], en[0]);
        end

        // R9: trigger ignores ack, cleared by write
        pulse_ack(3'b100);
        check("R9 trigger ack ignored", flag_o[2], 1'b1);
        sw_write(3'b100, 3'b000);
        check("R9 trigger sw clear", flag_o[2], 1'b0);

        // R10: write beats simultaneous set; level-mode write has no effect
        do_reset(2'b00);
        trig_en_i = 1'b1;
        settle(3'b111); strobe();
        settle(3'b011);
        sw_wr_i = 3'b100; sw_wdata_i = 3'b000;
        strobe();
        sw_wr_i = '0;
        check("R10 write over set", flag_o[2], 1'b0);
        sw_write(3'b100, 3'b100);
        check("R10 write sets trigger", flag_o[2], 1'b1);
        settle(3'b111); strobe();
        sw_write(3'b001, 3'b001);
        check("R10 level write ignored", flag_o[0], 1'b0);

        // R11: strobe one edge after change misses, two edges after sees it
        do_reset(2'b01);
        settle(3'b111); strobe();
        pin_i = 3'b110;
        @(negedge clk);
        strobe();
        check("R11 strobe at B misses", flag_o[0], 1'b0);
        do_reset(2'b01);
        settle(3'b111); strobe();
        pin_i = 3'b110;
        @(negedge clk);
        @(negedge clk);
        strobe();
        check("R11 strobe at C sees", flag_o[0], 1'b1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule